// File: doc/BRIEF.md
# Printer Port with Sticky Acknowledge Latch

This block is a register-mapped parallel printer port on an 8-bit host bus. The host writes a byte that drives eight printer data outputs. It writes a control register that drives the strobe and init lines. It reads a status register that shows the printer's busy and fault inputs and a sticky flag recording an acknowledge pulse. The strobe pulse width and the whole handshake are left to host software. The block only holds the levels the host writes and records what the printer reports.

The acknowledge input is active low and may pulse for a single clock. It passes through a two-flop synchronizer together with busy and fault. A falling edge of the synchronized acknowledge sets a latch. The latch stays set until the host writes a 1 to the clear bit of the control register. If an edge and a clear land in the same cycle, the set wins, so no acknowledge is lost.

The host bus is a plain register strobe interface with no back-pressure. A write takes effect on every clock edge at which chip select and write are both high. A read is combinational: while chip select and output enable are high and write is low, the status value and its drive enable appear in the same cycle. Only the low three address bits are decoded. Locations that belong to other functions of a larger port chip never drive the bus and ignore writes.

Top module: `lpt_ackport`

## Requirements
- R1: A write (cs=1, we=1 at a clock edge) to decoded address 3'b101 loads din[7:0] onto pd_out[7:0] after that edge.
- R2: A write to decoded address 3'b110 sets strb_out from din bit 0 and init_out from din bit 1, and leaves pd_out unchanged.
- R3: A write to decoded address 3'b110 with din bit 2 = 1 clears the acknowledge latch. With din bit 2 = 0 the latch is left as it was. Bit 2 is an action and is never stored.
- R4: A read (cs=1, oe=1, we=0) of decoded address 3'b100 drives bus_doe=1 in the same cycle, with bus_dout bit 0 = busy, bit 1 = fault, bit 2 = acknowledge latch, and bits 7..3 = 0.
- R5: A falling edge on ack_n_in, including a low pulse only one clock long, sets the acknowledge latch. The latch stays set through later input activity until it is cleared by R3. A rising edge does not set it.
- R6: Address bit 3 is ignored, so addresses a and a+8 reach the same register.
- R7: While rst is high, pd_out, strb_out, init_out and the acknowledge latch are 0, and writes have no effect.
- R8: When a latch-setting acknowledge edge and a clear write fall in the same cycle, the latch ends up set.
- R9: A read with cs or oe low, or of any decoded address other than 3'b100, gives bus_doe=0 and bus_dout=0. Writes to decoded addresses other than 3'b101 and 3'b110 change no output.
- R10: A change on busy_in or fault_in is not visible in status after one clock edge and is visible after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register address; bit 3 ignored |
| bus_cs | input | 1 | Chip select |
| bus_we | input | 1 | Write strobe, sampled at clock edge |
| bus_oe | input | 1 | Output enable for reads |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data, 0 when not driven |
| bus_doe | output | 1 | High when the block drives read data |
| pd_out | output | 8 | Printer data lines |
| strb_out | output | 1 | Printer strobe line |
| init_out | output | 1 | Printer init line |
| busy_in | input | 1 | Printer busy, asynchronous |
| fault_in | input | 1 | Printer fault, asynchronous |
| ack_n_in | input | 1 | Printer acknowledge, active low, asynchronous |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 4-bit address and two synchronizer stages. At this size every one of the 256 data bytes, every 3-bit control code, every one of the 16 addresses and every busy/fault combination can be swept exhaustively. The two-stage synchronizer gives fixed, countable latencies. A one-clock acknowledge pulse and a clear write can therefore be placed in exactly the same cycle, and the status reads can be placed exactly one and two edges after an input change.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int DEC_W = 3;

  localparam logic [DEC_W-1:0] REG_STATUS = 3'b100;
  localparam logic [DEC_W-1:0] REG_DATA   = 3'b101;
  localparam logic [DEC_W-1:0] REG_CTRL   = 3'b110;

  localparam int CTL_STRB   = 0;
  localparam int CTL_INIT   = 1;
  localparam int CTL_ACKCLR = 2;

  localparam int ST_BUSY  = 0;
  localparam int ST_FAULT = 1;
  localparam int ST_ACK   = 2;
  localparam int ST_USED  = 3;

  typedef struct packed {
    logic ack;
    logic fault;
    logic busy;
  } lpt_status_t;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_async;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/lpt_ack_latch.sv
module lpt_ack_latch (
  input  logic clk,
  input  logic rst,
  input  logic ack_n_s,
  input  logic clr,
  output logic lat
);
  logic prev_q;
  logic fall;

  assign fall = prev_q & ~ack_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      lat    <= 1'b0;
    end else begin
      prev_q <= ack_n_s;
      if (fall)     lat <= 1'b1;
      else if (clr) lat <= 1'b0;
    end
  end
endmodule

// File: rtl/lpt_bus_regs.sv
module lpt_bus_regs
  import lpt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic              oe,
  input  logic [DEC_W-1:0]  sel,
  input  logic [DATA_W-1:0] din,
  input  lpt_status_t       stat,
  output logic [DATA_W-1:0] pd,
  output logic              strb,
  output logic              init,
  output logic              ack_clr,
  output logic [DATA_W-1:0] dout,
  output logic              doe
);
  logic wr_data, wr_ctrl, rd_stat;

  assign wr_data = cs & we & (sel == REG_DATA);
  assign wr_ctrl = cs & we & (sel == REG_CTRL);
  assign rd_stat = cs & oe & ~we & (sel == REG_STATUS);
  assign ack_clr = wr_ctrl & din[CTL_ACKCLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      pd   <= '0;
      strb <= 1'b0;
      init <= 1'b0;
    end else begin
      if (wr_data) pd <= din;
      if (wr_ctrl) begin
        strb <= din[CTL_STRB];
        init <= din[CTL_INIT];
      end
    end
  end

  always_comb begin
    dout = '0;
    doe  = rd_stat;
    if (rd_stat) dout[ST_USED-1:0] = stat;
  end
endmodule

// File: rtl/lpt_ackport.sv
module lpt_ackport
  import lpt_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic [DATA_W-1:0] pd_out,
  output logic              strb_out,
  output logic              init_out,
  input  logic              busy_in,
  input  logic              fault_in,
  input  logic              ack_n_in
);
  localparam int IN_W = 3;

  logic [ADDR_W-1:DEC_W] addr_hi_unused;
  logic [IN_W-1:0]       raw_in, syn_in;
  logic                  ack_lat, ack_clr;
  lpt_status_t           stat;

  assign addr_hi_unused = bus_addr[ADDR_W-1:DEC_W];
  assign raw_in = {ack_n_in, fault_in, busy_in};

  lpt_sync #(.W(IN_W), .STAGES(SYNC_ST), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_in), .q_sync(syn_in)
  );

  lpt_ack_latch u_ack (
    .clk(clk), .rst(rst), .ack_n_s(syn_in[2]), .clr(ack_clr), .lat(ack_lat)
  );

  assign stat.busy  = syn_in[0];
  assign stat.fault = syn_in[1];
  assign stat.ack   = ack_lat;

  lpt_bus_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cs(bus_cs), .we(bus_we), .oe(bus_oe),
    .sel(bus_addr[DEC_W-1:0]), .din(bus_din), .stat(stat),
    .pd(pd_out), .strb(strb_out), .init(init_out), .ack_clr(ack_clr),
    .dout(bus_dout), .doe(bus_doe)
  );
endmodule

// File: rtl/lpt_ackport_chk.sv
module lpt_ackport_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_cs,
  input logic              bus_we,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_din,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_doe,
  input logic [DATA_W-1:0] pd_out,
  input logic              strb_out,
  input logic              init_out,
  input logic              ack_lat
);
  logic wr_d, wr_c, clr_w;
  assign wr_d  = bus_cs && bus_we && bus_addr[2:0] == 3'b101;
  assign wr_c  = bus_cs && bus_we && bus_addr[2:0] == 3'b110;
  assign clr_w = wr_c && bus_din[2];

  a_r1_data_load: assert property (@(posedge clk) disable iff (rst)
    wr_d |=> pd_out == $past(bus_din));

  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    wr_c |=> (strb_out == $past(bus_din[0]) && init_out == $past(bus_din[1])));

  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_d |=> $stable(pd_out));

  a_r4_status_form: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> (bus_dout[7:3] == 5'd0 && bus_addr[2:0] == 3'b100));

  a_r9_undriven: assert property (@(posedge clk)
    (!bus_cs || !bus_oe) |-> (!bus_doe && bus_dout == '0));

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (ack_lat && !clr_w) |=> ack_lat);

  a_r7_reset: assert property (@(posedge clk)
    $past(rst) |-> (pd_out == '0 && !strb_out && !init_out && !ack_lat));
endmodule

bind lpt_ackport lpt_ackport_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_cs(bus_cs),
  .bus_we(bus_we), .bus_oe(bus_oe), .bus_din(bus_din),
  .bus_dout(bus_dout), .bus_doe(bus_doe), .pd_out(pd_out),
  .strb_out(strb_out), .init_out(init_out), .ack_lat(ack_lat)
);

// File: tb/lpt_ackport_tb.sv
`timescale 1ns/1ps
module lpt_ackport_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       cs = 1'b0, we = 1'b0, oe = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout, pd;
  logic       doe, strb, init;
  logic       busy = 1'b0, fault = 1'b0, ack_n = 1'b1;
  int         total = 0, bad = 0;
  bit         done = 1'b0;
  logic [7:0] rv;
  logic       re;

  always #10 clk = ~clk;

  lpt_ackport u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_cs(cs), .bus_we(we),
    .bus_oe(oe), .bus_din(din), .bus_dout(dout), .bus_doe(doe),
    .pd_out(pd), .strb_out(strb), .init_out(init),
    .busy_in(busy), .fault_in(fault), .ack_n_in(ack_n)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; din = d; cs = 1'b1; we = 1'b1;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, output logic e);
    addr = a; cs = 1'b1; oe = 1'b1; we = 1'b0;
    #2;
    d = dout; e = doe;
    cs = 1'b0; oe = 1'b0;
  endtask

  function automatic logic [7:0] st(input logic b, input logic f, input logic k);
    return {5'b0, k, f, b};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R7: reset state and writes blocked while reset is high
    repeat (2) @(negedge clk);
    wr(4'h5, 8'hA5);
    wr(4'h6, 8'h03);
    chk("R7 pd in reset", pd, 8'h00);
    chk("R7 strb/init in reset", {strb, init}, 2'b00);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'h4, rv, re);
    chk("R7 latch after reset", {re, rv}, {1'b1, 8'h00});

    // R1/R6: every data byte, alternating alias halves
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      wr((v % 2 == 0) ? 4'h5 : 4'hD, v[7:0]);
      chk("R1 pd load", pd, v[7:0]);
    end

    // R2/R3: every control code, pd untouched
    wr(4'h5, 8'h3C);
    for (int c = 0; c < 8; c++) begin
      wr((c % 2 == 0) ? 4'h6 : 4'hE, c[7:0] | 8'hF8);
      chk("R2 strb", strb, c[0]);
      chk("R2 init", init, c[1]);
      chk("R2 pd unchanged", pd, 8'h3C);
    end

    // R9: writes elsewhere change nothing
    wr(4'h5, 8'h5A);
    wr(4'h6, 8'h01);
    for (int a = 0; a < 16; a++) begin
      if (a[2:0] != 3'b101 && a[2:0] != 3'b110) begin
        wr(a[3:0], 8'hFF);
        chk("R9 pd after foreign write", pd, 8'h5A);
        chk("R9 ctrl after foreign write", {strb, init}, 2'b10);
      end
    end

    // R4/R6/R9: read every address, with and without oe
    busy = 1'b1; fault = 1'b0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], rv, re);
      if (a[2:0] == 3'b100) chk("R4 status read", {re, rv}, {1'b1, st(1'b1, 1'b0, 1'b0)});
      else                  chk("R9 other read undriven", {re, rv}, 9'h000);
      addr = a[3:0]; cs = 1'b1; oe = 1'b0; #2;
      chk("R9 oe low undriven", {doe, dout}, 9'h000);
      cs = 1'b0;
      @(negedge clk);
    end

    // R10/R4: busy/fault combinations and two-edge latency
    for (int k = 0; k < 4; k++) begin
      logic ob, of;
      ob = busy; of = fault;
      @(negedge clk);
      busy = k[0]; fault = k[1];
      @(negedge clk);
      rd(4'h4, rv, re);
      chk("R10 one edge old", rv, st(ob, of, 1'b0));
      @(negedge clk);
      rd(4'h4, rv, re);
      chk("R10 two edges new", rv, st(k[0], k[1], 1'b0));
    end
    busy = 1'b0; fault = 1'b0;
    repeat (3) @(negedge clk);

    // R5: one-clock low pulse sets the latch, which stays
    ack_n = 1'b0;
    @(negedge clk);
    ack_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'h4, rv, re);
    chk("R5 pulse sets latch", rv, st(1'b0, 1'b0, 1'b1));
    repeat (5) @(negedge clk);
    rd(4'hC, rv, re);
    chk("R5 latch sticky", rv, st(1'b0, 1'b0, 1'b1));

    // R3: bit 2 = 0 leaves it, bit 2 = 1 clears it
    @(negedge clk);
    wr(4'h6, 8'h03);
    rd(4'h4, rv, re);
    chk("R3 no clear with bit2=0", rv, st(1'b0, 1'b0, 1'b1));
    chk("R3 ctrl bits from write", {strb, init}, 2'b11);
    @(negedge clk);
    wr(4'h6, 8'h04);
    rd(4'h4, rv, re);
    chk("R3 clear with bit2=1", rv, st(1'b0, 1'b0, 1'b0));
    chk("R3 bit2 not in ctrl", {strb, init}, 2'b00);

    // R5: holding low, then a rising edge, does not set again
    @(negedge clk);
    ack_n = 1'b0;
    repeat (4) @(negedge clk);
    wr(4'h6, 8'h04);
    ack_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'h4, rv, re);
    chk("R5 rising edge no set", rv, st(1'b0, 1'b0, 1'b0));

    // R8: edge and clear in the same cycle
    @(negedge clk);
    ack_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr(4'h6, 8'h04);
    rd(4'h4, rv, re);
    chk("R8 set wins over clear", rv, st(1'b0, 1'b0, 1'b1));
    ack_n = 1'b1;

    // R7: reset in mid-run clears everything
    @(negedge clk);
    wr(4'h5, 8'hC3);
    wr(4'h6, 8'h03);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 mid-run reset outputs", {pd, strb, init}, 10'h000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'h4, rv, re);
    chk("R7 mid-run reset latch", rv, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule